// File: doc/BRIEF.md
# Routed Local Interrupt Controller

The block gathers 32 interrupt source lines. It qualifies each one by its own trigger mode and drives a grid of request lines: one line for each pairing of a processor core with a parent interrupt output. Each source line is sampled on the block clock. A level source shows its qualified level directly. An edge source captures a qualifying transition in a sticky latch, and software clears that latch by writing a one to the matching bit of the pending register.

Every source owns a routing byte. Its high nibble names the parent outputs the source may raise, and its low nibble names the cores. A parent/core request line goes high when at least one pending source names both that parent and that core. Enables are never written as a plain mask. Software sets them through one register, where each one written sets a bit, and clears them through another, where each one written clears a bit.

Software reaches all state through a simple single-cycle register bus. The bus has a request strobe, a write strobe, a byte address, 32 write data bits and four byte enables. Read data is combinational and valid while the request strobe is high.

Top module: `rlic_top`

## Requirements
- R1: After reset every source is disabled. The edge register reads 0, so every source is level triggered. The polarity register reads all ones. Every routing byte reads 0x00 and every request line is low.
- R2: The routing byte of source n sits at byte address n (0x00 to 0x1F). It is read as lane n mod 4 of the little-endian word at address 4*(n div 4). A write updates only the bytes whose byte enables are set.
- R3: A write to 0x28 sets every enable bit written as one and leaves the others alone. A write to 0x2C clears every enable bit written as one. The enable vector reads back at 0x24, with bit n belonging to source n.
- R4: A level source (edge bit 0) with polarity bit 1 is pending while its input is high. With polarity bit 0 it is pending while its input is low. Its pending bit follows the input and is not latched.
- R5: An edge source (edge bit 1) latches pending on a rising input edge when its polarity bit is 1, and on a falling edge when the bit is 0. The pending bit stays set after the input returns.
- R6: Writing a one to bit n of 0x40 clears the edge latch of source n. Bits written as zero leave the other latches untouched.
- R7: A disabled source never shows in the pending register at 0x40 and raises no request line.
- R8: Request line irq_o[c*N_PAR+k] is high when any pending source has routing bit 4+k and routing bit c both set. It is registered one cycle after the pending state.
- R9: Reads of undefined addresses return zero. Writes to 0x24 change nothing. A write to 0x40 does not affect the pending bit of a level source.
- R10: Polarity (0x30) and edge (0x34) are plain read/write registers, with bit n belonging to source n, and they obey the byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Interrupt source lines, already in the clock domain |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | N_CORE*N_PAR | Request lines, index core*N_PAR+parent |

## Verification
The bench builds the block with its defaults: 32 sources, four parents, four cores and an 8-bit address. With those values the whole register map is reachable, along with all sixteen request lines. Every routing lane of every word can be driven. Random routing bytes, enable changes, trigger modes and source toggles are compared each step against a bench model of the latches, the pending register and the request grid.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
  localparam int DW = 32;
  localparam logic [7:0] OFF_EN_STAT = 8'h24;
  localparam logic [7:0] OFF_EN_SET  = 8'h28;
  localparam logic [7:0] OFF_EN_CLR  = 8'h2C;
  localparam logic [7:0] OFF_POL     = 8'h30;
  localparam logic [7:0] OFF_EDGE    = 8'h34;
  localparam logic [7:0] OFF_PEND    = 8'h40;
  localparam int PAR_LSB = 4;

  function automatic logic [DW-1:0] be_mask(input logic [3:0] be);
    for (int b = 0; b < 4; b++) be_mask[8*b +: 8] = {8{be[b]}};
  endfunction
endpackage

// File: rtl/rlic_regs.sv
module rlic_regs
  import rlic_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [3:0]       be_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_SRC-1:0] pend_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] pol_o,
  output logic [N_SRC-1:0] edge_o,
  output logic [N_SRC-1:0] pend_clr_o,
  output logic [N_SRC*8-1:0] route_o
);
  localparam int RT_WORDS = N_SRC / 4;
  localparam int WIW      = AW - 2;

  logic [WIW-1:0]   widx;
  logic             wr;
  logic [N_SRC-1:0] wm, wd;
  logic [N_SRC-1:0] en_q, pol_q, edge_q;
  logic [7:0]       route_q [N_SRC];

  assign widx = addr_i[AW-1:2];
  assign wr   = req_i && we_i;
  assign wm   = N_SRC'(be_mask(be_i));
  assign wd   = wdata_i[N_SRC-1:0] & wm;

  function automatic logic hit(input logic [WIW-1:0] w, input logic [7:0] off);
    return w == WIW'(off >> 2);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '1;
      edge_q <= '0;
    end else if (wr) begin
      if (hit(widx, OFF_EN_SET)) en_q   <= en_q | wd;
      if (hit(widx, OFF_EN_CLR)) en_q   <= en_q & ~wd;
      if (hit(widx, OFF_POL))    pol_q  <= (pol_q & ~wm) | wd;
      if (hit(widx, OFF_EDGE))   edge_q <= (edge_q & ~wm) | wd;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_rt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[i] <= '0;
      else if (wr && widx == WIW'(i / 4) && be_i[i % 4])
        route_q[i] <= wdata_i[8*(i%4) +: 8];
    end
    assign route_o[8*i +: 8] = route_q[i];
  end

  assign pend_clr_o = (wr && hit(widx, OFF_PEND)) ? wd : '0;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (int'(widx) < RT_WORDS) begin
        for (int b = 0; b < 4; b++) rdata_o[8*b +: 8] = route_q[int'(widx)*4 + b];
      end else if (hit(widx, OFF_EN_STAT)) rdata_o[N_SRC-1:0] = en_q;
      else if (hit(widx, OFF_POL))         rdata_o[N_SRC-1:0] = pol_q;
      else if (hit(widx, OFF_EDGE))        rdata_o[N_SRC-1:0] = edge_q;
      else if (hit(widx, OFF_PEND))        rdata_o[N_SRC-1:0] = pend_i;
    end
  end

  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit(widx, OFF_EN_SET)) |=> ((en_q & $past(wd)) == $past(wd)));
  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit(widx, OFF_EN_CLR)) |=> ((en_q & $past(wd)) == '0));
  // R9
  en_stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit(widx, OFF_EN_STAT)) |=> $stable(en_q));
endmodule

// File: rtl/rlic_detect.sv
module rlic_detect #(
  parameter int N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] s_q, s_qq, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= '0;
      s_qq <= '0;
    end else begin
      s_q  <= src_i;
      s_qq <= s_q;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic evt, lvl;
    assign evt = pol_i[i] ? (s_q[i] & ~s_qq[i]) : (~s_q[i] & s_qq[i]);
    assign lvl = ~(s_q[i] ^ pol_i[i]);

    // a capture in the same cycle as a clear wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q[i] <= 1'b0;
      else lat_q[i] <= (lat_q[i] & ~clr_i[i]) | (evt & edge_i[i] & en_i[i]);
    end

    assign pend_o[i] = en_i[i] & (edge_i[i] ? lat_q[i] : lvl);

    // R5
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[i] && en_i[i] && pend_o[i] && !clr_i[i])
        |=> (pend_o[i] || !edge_i[i] || !en_i[i]));
  end
endmodule

// File: rtl/rlic_router.sv
module rlic_router
  import rlic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_PAR  = 4,
  parameter int N_CORE = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*8-1:0]      route_i,
  output logic [N_CORE*N_PAR-1:0] irq_o
);
  logic [N_CORE*N_PAR-1:0] irq_d;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    for (genvar k = 0; k < N_PAR; k++) begin : g_par
      always_comb begin
        irq_d[c*N_PAR+k] = 1'b0;
        for (int i = 0; i < N_SRC; i++)
          irq_d[c*N_PAR+k] |= pend_i[i] & route_i[8*i+c] & route_i[8*i+PAR_LSB+k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end

  // R8
  quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_i) |=> (irq_o == '0));
endmodule

// File: rtl/rlic_top.sv
module rlic_top
  import rlic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_PAR  = 4,
  parameter int N_CORE = 4,
  parameter int AW     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [3:0]              be_i,
  output logic [31:0]             rdata_o,
  output logic [N_CORE*N_PAR-1:0] irq_o
);
  logic [N_SRC-1:0]   en, pol, edg, clr, pend;
  logic [N_SRC*8-1:0] route;

  rlic_regs #(.N_SRC(N_SRC), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .rdata_o,
    .pend_i(pend), .en_o(en), .pol_o(pol), .edge_o(edg),
    .pend_clr_o(clr), .route_o(route)
  );

  rlic_detect #(.N_SRC(N_SRC)) u_detect (
    .clk_i, .rst_ni, .src_i, .en_i(en), .pol_i(pol), .edge_i(edg),
    .clr_i(clr), .pend_o(pend)
  );

  rlic_router #(.N_SRC(N_SRC), .N_PAR(N_PAR), .N_CORE(N_CORE)) u_router (
    .clk_i, .rst_ni, .pend_i(pend), .route_i(route), .irq_o
  );

  // R7
  pend_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~en) == '0);
endmodule

// File: tb/rlic_top_tb.sv
module rlic_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32, NP = 4, NC = 4;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src = '0;
  logic req = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] be = '0;
  logic [31:0] rdata;
  logic [NC*NP-1:0] irq;

  int checks = 0, fails = 0;

  // bench model
  logic [31:0] m_en = '0, m_pol = '1, m_edg = '0, m_lat = '0, m_src = '0;
  logic [7:0]  m_rt [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  rlic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] bm(input logic [3:0] b);
    for (int i = 0; i < 4; i++) bm[8*i +: 8] = {8{b[i]}};
  endfunction

  function automatic logic [31:0] exp_pend();
    return m_en & ((m_edg & m_lat) | (~m_edg & ~(m_src ^ m_pol)));
  endfunction

  function automatic logic [NC*NP-1:0] exp_irq();
    logic [31:0] p = exp_pend();
    exp_irq = '0;
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < NP; k++)
        for (int i = 0; i < NS; i++)
          if (p[i] && m_rt[i][c] && m_rt[i][4+k]) exp_irq[c*NP+k] = 1'b1;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    logic [31:0] m = bm(b);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0;
    if (a < 8'h20) begin
      for (int l = 0; l < 4; l++) if (b[l]) m_rt[(a >> 2)*4 + l] = d[8*l +: 8];
    end else case (a & 8'hFC)
      8'h28: m_en  = m_en | (d & m);
      8'h2C: m_en  = m_en & ~(d & m);
      8'h30: m_pol = (m_pol & ~m) | (d & m);
      8'h34: m_edg = (m_edg & ~m) | (d & m);
      8'h40: m_lat = m_lat & ~(d & m);
      default: ;
    endcase
    wait_cyc(3);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic set_src(input logic [31:0] v);
    logic [31:0] rise = v & ~m_src, fall = ~v & m_src;
    m_lat = m_lat | (m_en & m_edg & ((m_pol & rise) | (~m_pol & fall)));
    m_src = v;
    @(negedge clk);
    src = v;
    wait_cyc(4);
  endtask

  task automatic check_all(input string r);
    logic [31:0] d;
    bus_rd(8'h24, d); chk({r, " en"}, d, m_en);
    bus_rd(8'h30, d); chk({r, " pol"}, d, m_pol);
    bus_rd(8'h34, d); chk({r, " edge"}, d, m_edg);
    bus_rd(8'h40, d); chk({r, " pend"}, d, exp_pend());
    chk({r, " irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NS; i++) m_rt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    wait_cyc(1);

    // R1 reset state
    bus_rd(8'h24, d); chk("R1 en", d, 32'h0);
    bus_rd(8'h34, d); chk("R1 edge", d, 32'h0);
    bus_rd(8'h30, d); chk("R1 pol", d, 32'hFFFF_FFFF);
    bus_rd(8'h1C, d); chk("R1 route", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 byte lanes
    bus_wr(8'h04, 32'h0000_A500, 4'b0010);
    bus_rd(8'h04, d); chk("R2 lane1", d, 32'h0000_A500);
    bus_wr(8'h04, 32'hFFFF_FF11, 4'b0001);
    bus_rd(8'h04, d); chk("R2 lane0", d, 32'h0000_A511);

    // R3 set/clear
    bus_wr(8'h28, 32'h0000_000F, 4'hF);
    bus_wr(8'h28, 32'h0000_00F0, 4'hF);
    bus_rd(8'h24, d); chk("R3 set", d, 32'h0000_00FF);
    bus_wr(8'h2C, 32'h0000_000C, 4'hF);
    bus_rd(8'h24, d); chk("R3 clr", d, 32'h0000_00F3);
    bus_wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    bus_rd(8'h24, d); chk("R3 clr all", d, 32'h0);

    // R4 / R8 level source 0 -> parent0, core0
    bus_wr(8'h00, 32'h0000_0011, 4'b0001);
    bus_wr(8'h28, 32'h0000_0001, 4'hF);
    set_src(32'h1);
    bus_rd(8'h40, d); chk("R4 level high", d, 32'h1);
    chk("R8 irq c0p0", 32'(irq), 32'h1);
    bus_wr(8'h30, 32'hFFFF_FFFE, 4'hF);
    bus_rd(8'h40, d); chk("R4 level low inactive", d, 32'h0);
    set_src(32'h0);
    bus_rd(8'h40, d); chk("R4 level low active", d, 32'h1);
    // R9 clear write has no effect on level source
    bus_wr(8'h40, 32'h1, 4'hF);
    bus_rd(8'h40, d); chk("R9 level w1c", d, 32'h1);
    bus_wr(8'h30, 32'hFFFF_FFFF, 4'hF);

    // R5 / R6 edge source 3 -> parent3, core1 (irq index 7)
    bus_wr(8'h00, 32'h8200_0000, 4'b1000);
    bus_wr(8'h34, 32'h0000_0008, 4'hF);
    bus_wr(8'h28, 32'h0000_0008, 4'hF);
    set_src(32'h8);
    set_src(32'h0);
    bus_rd(8'h40, d); chk("R5 rise latched", d, 32'h8);
    chk("R8 irq c1p3", 32'(irq), 32'h80);
    bus_wr(8'h40, 32'h8, 4'hF);
    bus_rd(8'h40, d); chk("R6 w1c", d, 32'h0);
    bus_wr(8'h30, 32'hFFFF_FFF7, 4'hF);
    set_src(32'h8);
    bus_rd(8'h40, d); chk("R5 fall ignores rise", d, 32'h0);
    set_src(32'h0);
    bus_rd(8'h40, d); chk("R5 fall latched", d, 32'h8);

    // R7 disabled level source 5
    bus_wr(8'h04, 32'h0000_FF00, 4'b0010);
    set_src(32'h20);
    bus_rd(8'h40, d); chk("R7 masked pend", d & 32'h20, 32'h0);
    chk("R7 masked irq", 32'(irq), 32'(exp_irq()));

    // R9 undefined offsets and status write
    bus_rd(8'h20, d); chk("R9 rd 20", d, 32'h0);
    bus_rd(8'h38, d); chk("R9 rd 38", d, 32'h0);
    bus_rd(8'h44, d); chk("R9 rd 44", d, 32'h0);
    bus_rd(8'h28, d); chk("R9 rd 28", d, 32'h0);
    bus_wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    bus_rd(8'h24, d); chk("R9 en ro", d, m_en);

    // R10 byte-enabled pol/edge
    bus_wr(8'h34, 32'hAAAA_AAAA, 4'b0100);
    bus_rd(8'h34, d); chk("R10 edge lane2", d, m_edg);
    check_all("R10");

    // random mix, R2 R3 R4 R5 R6 R8 R10
    for (int it = 0; it < 150; it++) begin
      v = $urandom;
      case ($urandom % 7)
        0: bus_wr(8'(($urandom % 8) * 4), v, 4'($urandom));
        1: bus_wr(8'h28, v, 4'hF);
        2: bus_wr(8'h2C, v & $urandom, 4'hF);
        3: bus_wr(8'h30, v, 4'($urandom));
        4: bus_wr(8'h34, v, 4'($urandom));
        5: bus_wr(8'h40, v, 4'hF);
        default: set_src(v);
      endcase
      check_all("R8 rand");
      begin
        int w = $urandom % 8;
        bus_rd(8'(w * 4), d);
        chk("R2 rand route", d, {m_rt[w*4+3], m_rt[w*4+2], m_rt[w*4+1], m_rt[w*4]});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule